// File: doc/BRIEF.md
# Write-Back Invalidating Snoop Cache Controller

This block is the per-node cache controller of a small shared-memory multiprocessor whose nodes share one atomic bus. Each line of its direct-mapped store holds one word, a tag and one of three coherence states: Invalid, Shared or Modified. There is no exclusive-clean state, so a line that has just been filled for a read is always Shared. A write to a line that is not already Modified is sent to the bus as a write miss.

The processor side issues one read or write at a time. Hits complete without using the bus. A miss can evict a dirty line that sits at the same index. In that case the controller first writes that line back, then issues the read miss or write miss for the new block. The bus completes each transaction atomically with a single acknowledge cycle, which also returns fill data.

Every miss placed on the bus by another node is presented on the snoop input. When this node holds the requested block dirty, it flushes the word, tells memory to abandon its own reply and, for a read miss, hands the word to the requester. Across all nodes the protocol keeps each block in one of three situations: clean in any number of caches, dirty in exactly one, or cached nowhere.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid with zero data. `cpu_req_ready` is 1, and `bus_req_valid`, `cpu_resp_valid`, `snp_flush`, `snp_supply` and `snp_abort` are 0. The first access to any address is therefore a miss.
- R2: A read to an Invalid line raises a bus request with `bus_req_cmd` = 2'b01 (read miss) at the request address. On `bus_ack` the word on `bus_rdata` is installed as Shared. In the next cycle `cpu_resp_valid` is 1 with that word.
- R3: A write to an Invalid line, or to a Shared line with the same tag, raises `bus_req_cmd` = 2'b10 (write miss). On `bus_ack` the line takes the write data and becomes Modified.
- R4: A read hit (Shared or Modified) and a write hit (Modified) raise no bus request. They give `cpu_resp_valid` one cycle after the request is accepted, and a read returns the stored word. `cpu_resp_valid` is only ever raised after an accepted request or a bus acknowledge.
- R5: A snooped write miss (`snp_cmd` = 2'b10) that matches a Shared line makes the line Invalid, with no flush and no supply.
- R6: A snooped write miss that matches a Modified line makes the line Invalid. One cycle later it raises `snp_flush` and `snp_abort` with the line's word on `snp_data`, and `snp_supply` stays 0.
- R7: A snooped read miss (`snp_cmd` = 2'b01) that matches a Modified line makes the line Shared. One cycle later it raises `snp_flush`, `snp_abort` and `snp_supply` with the line's word.
- R8: A snooped read miss that matches a Shared line, or any snoop that misses (Invalid line or a different tag), changes no state and raises no snoop output.
- R9: A miss whose index holds a Modified line with a different tag first raises `bus_req_cmd` = 2'b11 (write-back). That request carries the victim's address and word. After its `bus_ack` the controller issues the read or write miss for the new block.
- R10: A miss whose index holds a clean line (Shared) with a different tag issues the miss directly, with no write-back.
- R11: If a snoop takes away the Modified victim while its write-back is still waiting for `bus_ack`, the write-back is dropped. From the next cycle the request is the miss for the new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address; the low bits select the line |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_req_ready | output | 1 | Controller idle; a request is accepted when valid and ready |
| cpu_resp_valid | output | 1 | Request complete |
| cpu_resp_rdata | output | DATA_W | Read result |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 01 read miss, 10 write miss, 11 write-back |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_wdata | output | DATA_W | Write-back word |
| bus_ack | input | 1 | Requested transaction completed this cycle |
| bus_rdata | input | DATA_W | Fill word returned with `bus_ack` |
| snp_valid | input | 1 | Another node's transaction is visible |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_req_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This node writes its dirty word back |
| snp_supply | output | 1 | This node's word goes to the requesting node |
| snp_abort | output | 1 | Memory must not answer the snooped miss |
| snp_data | output | DATA_W | Flushed or supplied word |

## Verification
The bench builds the controller with 8-bit addresses, 16-bit words and four lines. That leaves a 2-bit index and a 6-bit tag, so addresses such as 0x10 and 0x30 collide on the same line with little effort. With this setup every path of the state machine can be reached: eviction with and without a write-back, upgrade of a Shared line, and a snoop that arrives while a write-back is still waiting. Every line state can be told apart from the ports alone, by following a snoop with a processor access that either hits or goes to the bus.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_M = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CF_IDLE  = 2'd0,
        CF_WBACK = 2'd1,
        CF_MISS  = 2'd2
    } ctl_st_e;

endpackage

// File: rtl/msi_snoop_decode.sv
module msi_snoop_decode
    import msi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  line_st_e           line_st,
    input  logic [TAG_W-1:0]   line_tag,
    input  logic [TAG_W-1:0]   snp_tag,
    input  logic [1:0]         snp_cmd,
    output line_st_e           next_st,
    output logic               flush,
    output logic               supply
);
    logic match;

    always_comb begin
        match   = (line_st != LS_I) && (line_tag == snp_tag);
        next_st = line_st;
        flush   = 1'b0;
        supply  = 1'b0;
        if (match) begin
            if (snp_cmd == BC_RDMISS) begin
                // another node reads: a dirty copy is flushed and shared
                if (line_st == LS_M) begin
                    next_st = LS_S;
                    flush   = 1'b1;
                    supply  = 1'b1;
                end
            end else if (snp_cmd == BC_WRMISS) begin
                // another node writes: every local copy dies
                next_st = LS_I;
                flush   = (line_st == LS_M);
            end
        end
    end
endmodule

// File: rtl/msi_cpu_decode.sv
module msi_cpu_decode
    import msi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  line_st_e           line_st,
    input  logic [TAG_W-1:0]   line_tag,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic               req_we,
    output logic               hit,
    output logic               need_wb,
    output bus_cmd_e           miss_cmd
);
    logic tag_eq;

    always_comb begin
        tag_eq   = (line_tag == req_tag);
        // a write counts as a hit only on a dirty line
        hit      = tag_eq && (req_we ? (line_st == LS_M) : (line_st != LS_I));
        need_wb  = (line_st == LS_M) && !tag_eq;
        miss_cmd = req_we ? BC_WRMISS : BC_RDMISS;
    end
endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush,
    output logic              snp_supply,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct {
        ctl_st_e           fsm;
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] wdata;
        logic              resp_v;
        logic [DATA_W-1:0] resp_d;
        logic              s_flush;
        logic              s_supply;
        logic [DATA_W-1:0] s_data;
        line_st_e          st   [LINES];
        logic [TAG_W-1:0]  ltag [LINES];
        logic [DATA_W-1:0] ldat [LINES];
    } ctl_t;

    ctl_t q, d;

    // ---------------- bus completion this cycle ----------------
    logic              ack_fill, ack_wb;
    line_st_e          fill_st;
    logic [DATA_W-1:0] fill_data;

    assign ack_fill  = (q.fsm == CF_MISS)  && bus_ack;
    assign ack_wb    = (q.fsm == CF_WBACK) && bus_ack;
    assign fill_st   = q.we ? LS_M : LS_S;
    assign fill_data = q.we ? q.wdata : bus_rdata;

    // ---------------- snoop view: line after own bus completion ----------------
    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  snp_tag;
    line_st_e          sv_st;
    logic [TAG_W-1:0]  sv_tag;
    logic [DATA_W-1:0] sv_dat;
    logic [1:0]        snp_cmd_eff;
    line_st_e          sn_nst;
    logic              sn_flush, sn_supply;

    assign snp_idx     = snp_addr[IDX_W-1:0];
    assign snp_tag     = snp_addr[ADDR_W-1:IDX_W];
    assign snp_cmd_eff = snp_valid ? snp_cmd : BC_NONE;

    always_comb begin
        sv_st  = q.st[snp_idx];
        sv_tag = q.ltag[snp_idx];
        sv_dat = q.ldat[snp_idx];
        if (ack_fill && (q.idx == snp_idx)) begin
            sv_st  = fill_st;
            sv_tag = q.tag;
            sv_dat = fill_data;
        end
        if (ack_wb && (q.idx == snp_idx)) begin
            sv_st = LS_I;
        end
    end

    msi_snoop_decode #(.TAG_W(TAG_W)) u_snp_dec (
        .line_st  (sv_st),
        .line_tag (sv_tag),
        .snp_tag  (snp_tag),
        .snp_cmd  (snp_cmd_eff),
        .next_st  (sn_nst),
        .flush    (sn_flush),
        .supply   (sn_supply)
    );

    // ---------------- processor view: line after the snoop ----------------
    logic [IDX_W-1:0]  cv_idx;
    logic [TAG_W-1:0]  cv_rtag;
    logic              cv_we;
    line_st_e          cv_st;
    logic [TAG_W-1:0]  cv_tag;
    logic [DATA_W-1:0] cv_dat;
    logic              hit, need_wb;
    bus_cmd_e          miss_cmd;

    always_comb begin
        if (q.fsm == CF_IDLE) begin
            cv_idx  = cpu_req_addr[IDX_W-1:0];
            cv_rtag = cpu_req_addr[ADDR_W-1:IDX_W];
            cv_we   = cpu_req_we;
        end else begin
            cv_idx  = q.idx;
            cv_rtag = q.tag;
            cv_we   = q.we;
        end
        cv_st  = q.st[cv_idx];
        cv_tag = q.ltag[cv_idx];
        cv_dat = q.ldat[cv_idx];
        if (ack_wb && (q.idx == cv_idx)) begin
            cv_st = LS_I;
        end
        if (snp_valid && (snp_idx == cv_idx)) begin
            cv_st = sn_nst;
        end
    end

    msi_cpu_decode #(.TAG_W(TAG_W)) u_cpu_dec (
        .line_st  (cv_st),
        .line_tag (cv_tag),
        .req_tag  (cv_rtag),
        .req_we   (cv_we),
        .hit      (hit),
        .need_wb  (need_wb),
        .miss_cmd (miss_cmd)
    );

    // ---------------- next state ----------------
    always_comb begin
        d          = q;
        d.resp_v   = 1'b0;
        d.s_flush  = 1'b0;
        d.s_supply = 1'b0;

        // 1. own bus transaction completes (first in bus order)
        if (ack_fill) begin
            d.st[q.idx]   = fill_st;
            d.ltag[q.idx] = q.tag;
            d.ldat[q.idx] = fill_data;
            d.resp_v      = 1'b1;
            d.resp_d      = fill_data;
            d.fsm         = CF_IDLE;
        end
        if (ack_wb) begin
            d.st[q.idx] = LS_I;
        end

        // 2. another node's transaction
        if (snp_valid) begin
            d.st[snp_idx] = sn_nst;
            d.s_flush     = sn_flush;
            d.s_supply    = sn_supply;
            if (sn_flush) begin
                d.s_data = sv_dat;
            end
        end

        // 3. processor side
        case (q.fsm)
            CF_IDLE: begin
                if (cpu_req_valid) begin
                    d.we    = cpu_req_we;
                    d.idx   = cv_idx;
                    d.tag   = cv_rtag;
                    d.wdata = cpu_req_wdata;
                    if (hit) begin
                        d.resp_v = 1'b1;
                        d.resp_d = cpu_req_we ? cpu_req_wdata : cv_dat;
                        if (cpu_req_we) begin
                            d.ldat[cv_idx] = cpu_req_wdata;
                        end
                    end else if (need_wb) begin
                        d.fsm = CF_WBACK;
                    end else begin
                        d.fsm = CF_MISS;
                    end
                end
            end
            CF_WBACK: begin
                // victim written back, or taken by a snoop
                if (!need_wb) begin
                    d.fsm = CF_MISS;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.fsm      <= CF_IDLE;
            q.we       <= 1'b0;
            q.idx      <= '0;
            q.tag      <= '0;
            q.wdata    <= '0;
            q.resp_v   <= 1'b0;
            q.resp_d   <= '0;
            q.s_flush  <= 1'b0;
            q.s_supply <= 1'b0;
            q.s_data   <= '0;
            for (int i = 0; i < LINES; i++) begin
                q.st[i]   <= LS_I;
                q.ltag[i] <= '0;
                q.ldat[i] <= '0;
            end
        end else begin
            q <= d;
        end
    end

    // ---------------- outputs ----------------
    assign cpu_req_ready  = (q.fsm == CF_IDLE);
    assign cpu_resp_valid = q.resp_v;
    assign cpu_resp_rdata = q.resp_d;
    assign bus_req_valid  = (q.fsm != CF_IDLE);
    assign bus_req_cmd    = (q.fsm == CF_WBACK) ? BC_WBACK : miss_cmd;
    assign bus_req_addr   = (q.fsm == CF_WBACK) ? {q.ltag[q.idx], q.idx} : {q.tag, q.idx};
    assign bus_req_wdata  = (q.fsm == CF_WBACK) ? q.ldat[q.idx] : '0;
    assign snp_flush      = q.s_flush;
    assign snp_abort      = q.s_flush;
    assign snp_supply     = q.s_supply;
    assign snp_data       = q.s_data;

endmodule

// File: rtl/msi_cache_ctrl_chk.sv
module msi_cache_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_resp_valid,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_cmd,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              bus_ack,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic              snp_flush,
    input logic              snp_supply,
    input logic              snp_abort,
    input logic [DATA_W-1:0] snp_data
);
    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_ready |-> !bus_req_valid); // R4

    AST_RESP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |-> ($past(bus_ack && bus_req_valid) || $past(cpu_req_valid && cpu_req_ready))); // R4

    AST_MISS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_ack && bus_req_cmd != 2'b11)
        |=> (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr))); // R2

    AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_cmd == 2'b11 && bus_ack)
        |=> (bus_req_valid && bus_req_cmd != 2'b11)); // R9

    AST_WRMISS_NO_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == 2'b10) |=> !snp_supply); // R6

    AST_FLUSH_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> snp_abort); // R6

    AST_SUPPLY_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_flush && snp_abort)); // R7

    AST_QUIET_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |=> (!snp_flush && !snp_supply && !snp_abort)); // R8

    AST_FLUSH_DATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> !$isunknown(snp_data)); // R6
endmodule

bind msi_cache_ctrl msi_cache_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_resp_valid (cpu_resp_valid),
    .bus_req_valid  (bus_req_valid),
    .bus_req_cmd    (bus_req_cmd),
    .bus_req_addr   (bus_req_addr),
    .bus_ack        (bus_ack),
    .snp_valid      (snp_valid),
    .snp_cmd        (snp_cmd),
    .snp_flush      (snp_flush),
    .snp_supply     (snp_supply),
    .snp_abort      (snp_abort),
    .snp_data       (snp_data)
);

// File: tb/msi_cache_ctrl_tb.sv
module msi_cache_ctrl_tb;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_we = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_req_ready;
    logic          cpu_resp_valid;
    logic [DW-1:0] cpu_resp_rdata;
    logic          bus_req_valid;
    logic [1:0]    bus_req_cmd;
    logic [AW-1:0] bus_req_addr;
    logic [DW-1:0] bus_req_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_flush, snp_supply, snp_abort;
    logic [DW-1:0] snp_data;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    msi_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(4)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_we(cpu_req_we),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_req_ready(cpu_req_ready), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_rdata(cpu_resp_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
        .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_flush(snp_flush), .snp_supply(snp_supply),
        .snp_abort(snp_abort), .snp_data(snp_data)
    );

    // stimulus/expectation vector: first bus op c1 at address a1, optional second op c2
    typedef struct packed {
        logic          we;
        logic [7:0]    addr;
        logic [15:0]   wdata;
        logic [1:0]    c1;
        logic [7:0]    a1;
        logic [1:0]    c2;
        logic [15:0]   mem;
        logic [15:0]   exp;
        logic [15:0]   wbd;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h10, 16'h0000, 2'd1, 8'h10, 2'd0, 16'hA001, 16'hA001, 16'h0000, 4'd2 },  // R2 (R1: first access misses)
        '{1'b0, 8'h10, 16'h0000, 2'd0, 8'h00, 2'd0, 16'h0000, 16'hA001, 16'h0000, 4'd4 },  // R4 read hit S
        '{1'b1, 8'h10, 16'h1111, 2'd2, 8'h10, 2'd0, 16'hDEAD, 16'h0000, 16'h0000, 4'd3 },  // R3 write to S
        '{1'b0, 8'h10, 16'h0000, 2'd0, 8'h00, 2'd0, 16'h0000, 16'h1111, 16'h0000, 4'd4 },  // R4 read hit M
        '{1'b1, 8'h10, 16'h2222, 2'd0, 8'h00, 2'd0, 16'h0000, 16'h0000, 16'h0000, 4'd4 },  // R4 write hit M
        '{1'b0, 8'h10, 16'h0000, 2'd0, 8'h00, 2'd0, 16'h0000, 16'h2222, 16'h0000, 4'd4 },  // R4
        '{1'b1, 8'h21, 16'h3333, 2'd2, 8'h21, 2'd0, 16'h0000, 16'h0000, 16'h0000, 4'd3 },  // R3 write to I
        '{1'b0, 8'h22, 16'h0000, 2'd1, 8'h22, 2'd0, 16'hB002, 16'hB002, 16'h0000, 4'd2 },  // R2
        '{1'b0, 8'h32, 16'h0000, 2'd1, 8'h32, 2'd0, 16'hB003, 16'hB003, 16'h0000, 4'd10},  // R10 clean victim
        '{1'b0, 8'h30, 16'h0000, 2'd3, 8'h10, 2'd1, 16'hC004, 16'hC004, 16'h2222, 4'd9 },  // R9 dirty victim
        '{1'b0, 8'h10, 16'h0000, 2'd1, 8'h10, 2'd0, 16'h2222, 16'h2222, 16'h0000, 4'd10}   // R10
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic ack_bus(input logic [DW-1:0] data);
        bus_ack   = 1'b1;
        bus_rdata = data;
        @(posedge clk);
        @(negedge clk);
        bus_ack   = 1'b0;
    endtask

    task automatic cpu_op(input vec_t v, input string rq);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_we    = v.we;
        cpu_req_addr  = v.addr;
        cpu_req_wdata = v.wdata;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        if (v.c1 != 2'd0) begin
            chk(bus_req_valid && bus_req_cmd == v.c1, rq, "first bus cmd",
                {30'd0, bus_req_cmd}, {30'd0, v.c1});
            chk(bus_req_addr == v.a1, rq, "first bus addr", bus_req_addr, v.a1);
            if (v.c1 == 2'd3)
                chk(bus_req_wdata == v.wbd, rq, "write-back data", bus_req_wdata, v.wbd);
            ack_bus(v.mem);
            if (v.c2 != 2'd0) begin
                chk(bus_req_valid && bus_req_cmd == v.c2, rq, "second bus cmd",
                    {30'd0, bus_req_cmd}, {30'd0, v.c2});
                chk(bus_req_addr == v.addr, rq, "second bus addr", bus_req_addr, v.addr);
                ack_bus(v.mem);
            end
        end else begin
            chk(!bus_req_valid, rq, "no bus request on hit", bus_req_valid, 0);
        end
        chk(cpu_resp_valid, rq, "response valid", cpu_resp_valid, 1);
        if (!v.we)
            chk(cpu_resp_rdata == v.exp, rq, "read data", cpu_resp_rdata, v.exp);
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] addr,
                         input bit e_flush, input bit e_supply,
                         input logic [DW-1:0] e_data, input string rq);
        @(negedge clk);
        snp_valid = 1'b1;
        snp_cmd   = cmd;
        snp_addr  = addr;
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        chk(snp_flush == e_flush, rq, "snp_flush", snp_flush, e_flush);
        chk(snp_abort == e_flush, rq, "snp_abort", snp_abort, e_flush);
        chk(snp_supply == e_supply, rq, "snp_supply", snp_supply, e_supply);
        if (e_flush)
            chk(snp_data == e_data, rq, "snp_data", snp_data, e_data);
    endtask

    function automatic vec_t mk(input logic we, input logic [7:0] addr, input logic [15:0] wd,
                                input logic [1:0] c1, input logic [15:0] mem,
                                input logic [15:0] exp);
        vec_t v;
        v.we = we; v.addr = addr; v.wdata = wd; v.c1 = c1; v.a1 = addr;
        v.c2 = 2'd0; v.mem = mem; v.exp = exp; v.wbd = '0; v.rq = 4'd0;
        return v;
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        chk(cpu_req_ready, "R1", "ready in reset", cpu_req_ready, 1);
        chk(!bus_req_valid && !cpu_resp_valid, "R1", "quiet outputs in reset",
            {bus_req_valid, cpu_resp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!snp_flush && !snp_supply && !snp_abort, "R1", "quiet snoop after reset",
            {snp_flush, snp_supply, snp_abort}, 0);

        for (int i = 0; i < NV; i++) begin
            cpu_op(VECS[i], $sformatf("R%0d", VECS[i].rq));
        end
        // lines now: 0 S 0x10=2222, 1 M 0x21=3333, 2 S 0x32=B003, 3 I

        // R8: read miss snooped on a Shared line, on an Invalid line, on a tag mismatch
        snoop(2'd1, 8'h10, 1'b0, 1'b0, 16'h0, "R8");
        cpu_op(mk(1'b0, 8'h10, 16'h0, 2'd0, 16'h0, 16'h2222), "R8");
        snoop(2'd1, 8'h13, 1'b0, 1'b0, 16'h0, "R8");
        snoop(2'd1, 8'h01, 1'b0, 1'b0, 16'h0, "R8");
        cpu_op(mk(1'b0, 8'h21, 16'h0, 2'd0, 16'h0, 16'h3333), "R8");

        // R7: read miss snooped on Modified -> flush, supply, line Shared
        snoop(2'd1, 8'h21, 1'b1, 1'b1, 16'h3333, "R7");
        cpu_op(mk(1'b0, 8'h21, 16'h0, 2'd0, 16'h0, 16'h3333), "R7");
        cpu_op(mk(1'b1, 8'h21, 16'h4444, 2'd2, 16'h0, 16'h0), "R7");

        // R6: write miss snooped on Modified -> flush, no supply, line Invalid
        snoop(2'd2, 8'h21, 1'b1, 1'b0, 16'h4444, "R6");
        cpu_op(mk(1'b0, 8'h21, 16'h0, 2'd1, 16'h4444, 16'h4444), "R6");

        // R5: write miss snooped on Shared -> Invalid, silent
        snoop(2'd2, 8'h32, 1'b0, 1'b0, 16'h0, "R5");
        cpu_op(mk(1'b0, 8'h32, 16'h0, 2'd1, 16'hB005, 16'hB005), "R5");

        // R11: snoop steals dirty victim during pending write-back
        cpu_op(mk(1'b1, 8'h23, 16'h5555, 2'd2, 16'h0, 16'h0), "R11");
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_we    = 1'b1;
        cpu_req_addr  = 8'h33;
        cpu_req_wdata = 16'h6666;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk(bus_req_valid && bus_req_cmd == 2'd3, "R11", "write-back pending",
            {30'd0, bus_req_cmd}, 3);
        chk(bus_req_addr == 8'h23, "R11", "victim addr", bus_req_addr, 8'h23);
        snp_valid = 1'b1;
        snp_cmd   = 2'd2;
        snp_addr  = 8'h23;
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        chk(snp_flush && snp_data == 16'h5555, "R11", "snoop flushes victim", snp_data, 16'h5555);
        chk(bus_req_valid && bus_req_cmd == 2'd2, "R11", "request becomes write miss",
            {30'd0, bus_req_cmd}, 2);
        chk(bus_req_addr == 8'h33, "R11", "miss addr", bus_req_addr, 8'h33);
        ack_bus(16'h0);
        chk(cpu_resp_valid, "R11", "write completes", cpu_resp_valid, 1);
        cpu_op(mk(1'b0, 8'h33, 16'h0, 2'd0, 16'h0, 16'h6666), "R11");

        finish_run();
    end
endmodule